// File: doc/BRIEF.md
# BCD Calendar Clock with Sub-Second Countdown

This core keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of month, weekday, month and a two-digit year, plus a century flag. It is paced by an external enable strobe at `TICK_HZ` (32768 per second by default). The strobe drives an internal binary divider. The divider's wrap advances the seconds, and a lower tap of the same divider clocks a 64 Hz countdown timer. Because the timer and the seconds come from one divider, software can read the timer count at any moment to place a reading within the current second.

Software reaches the core through a byte-wide register port. The address selects a register, a one-cycle write strobe loads it, and a read strobe captures the addressed value into `rd_data` on the following edge. Reads show live values and nothing is frozen while reading. A run/stop bit pins the divider at its half-second point, so software can load a full time while the clock is stopped and release it. The first second then follows exactly half a second later. A sticky flag in the seconds register reports that the time has not been set since reset. Hours count in 24-hour form or in 12-hour form with an AM/PM bit.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the seconds register reads 0x80 (stale-time flag set, seconds 00). Minutes, hours, weekday, year, control 1, timer control and timer count read 0x00. Day and month read 0x01.
- R2: The register addresses are: control 1 at 0x0, seconds to year at 0x2 to 0x8 in the order seconds, minutes, hours, day, weekday, month, year, timer control at 0xE and timer count at 0xF. A read strobe loads `rd_data` at the next clock edge. Addresses 0x1 and 0x9 to 0xD, and every unused bit, read as 0, and writes to them have no effect.
- R3: Control 1 bit 5 is the stop bit. While it is 1, no time register or timer count advances and the divider is held at its half-second point. After it is cleared, the seconds advance on exactly the `TICK_HZ/2`-th strobe (16384 by default).
- R4: Seconds bit 7 is the stale-time flag. It is set by reset, changes only on a write to the seconds register, and takes bit 7 of that write.
- R5: In 24-hour mode (control 1 bit 3 = 0), seconds and minutes wrap from 59 to 00 with a carry, and hours wrap from 23 to 00 with a carry into the date.
- R6: In 12-hour mode (control 1 bit 3 = 1), hours bit 5 is PM and bits 4:0 hold the BCD hour 01 to 12. The sequence is 11 AM to 12 PM, 12 to 01 in the same half of the day, and 11 PM to 12 AM with a carry into the date.
- R7: The day wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and for month 02 either 29 when the BCD year is a multiple of 4 or 28 otherwise. The weekday (3 bits) counts 0 to 6 and wraps on each date carry. The month wraps from 12 to 01 with a carry into the year.
- R8: Month bit 7 is the century flag. It toggles when the year wraps from 99 to 00, and otherwise changes only on a write to the month register.
- R9: A write to any of the seven time registers clears the divider below its half-second bit. A write in the second half of a second therefore brings the next seconds advance exactly `TICK_HZ/2` strobes later, and no seconds advance happens on the strobe right after the write.
- R10: Timer control bit 7 enables the countdown, and bits 1:0 select the source, where 01 selects 64 Hz. Bits 6:2 read 0. Any other source code holds the count.
- R11: A write to the timer count loads both the count and its reload value. When the timer is enabled with the 64 Hz source, each `TICK_HZ/64` strobes one tick decrements the count, or reloads it when the count is 1 or 0. With a reload value of 64, the reload falls on the mid-second phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base strobe, `TICK_HZ` per second of kept time |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; the value is captured on this edge |
| rd_data | output | 8 | Captured read data |

## Verification
The bench builds the core with its default values, `TICK_HZ` = 32768 and `TMR_HZ` = 64. The exact 16384-strobe release delay and the 512-strobe timer step are therefore checked at their real counts. The timer reload at 64 ticks lands one full second after release, on the mid-second phase. The same build has room for one seconds step per scenario. That step is enough to drive the carries through the whole date: year and century rollover, 12-hour noon and midnight, leap February, and random dates biased toward field limits.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CTRL1 = 4'h0;
    localparam logic [REG_AW-1:0] A_SEC   = 4'h2;
    localparam logic [REG_AW-1:0] A_MIN   = 4'h3;
    localparam logic [REG_AW-1:0] A_HOUR  = 4'h4;
    localparam logic [REG_AW-1:0] A_DAY   = 4'h5;
    localparam logic [REG_AW-1:0] A_WDAY  = 4'h6;
    localparam logic [REG_AW-1:0] A_MON   = 4'h7;
    localparam logic [REG_AW-1:0] A_YEAR  = 4'h8;
    localparam logic [REG_AW-1:0] A_TCTL  = 4'hE;
    localparam logic [REG_AW-1:0] A_TCNT  = 4'hF;

    localparam int        BIT_STOP   = 5;
    localparam int        BIT_H12    = 3;
    localparam int        BIT_TEN    = 7;
    localparam logic [1:0] SRC_64HZ  = 2'b01;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic [4:0] mon;
        logic [7:0] year;
        logic       cent;
    } cal_t;

    // Add one to a two-digit BCD value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last BCD day of a month, leap February when the year is a multiple of 4.
    function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
        logic [7:0] yb;
        yb = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
        case (mon)
            5'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_rtc_divider.sv
module bcd_rtc_divider #(
    parameter int TICK_HZ = 32768,
    parameter int TMR_HZ  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic hold,
    input  logic clr_low,
    output logic sec_tick,
    output logic tmr_tick
);
    localparam int DW = $clog2(TICK_HZ);
    localparam int TW = $clog2(TICK_HZ / TMR_HZ);
    localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [DW-1:0] div;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold)          st_d.div = HALF;
        else if (clr_low)  st_d.div = st_q.div & HALF;
        else if (tick_en)  st_d.div = st_q.div + DW'(1);
    end

    assign sec_tick = tick_en && !hold && !clr_low && (&st_q.div);
    assign tmr_tick = tick_en && !hold && !clr_low && (&st_q.div[TW-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{div: HALF};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
    import bcd_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              mode_12h,
    input  logic              wr_time,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output cal_t              cal_q,
    output logic              stale_q
);
    typedef struct packed {
        logic stale;
        cal_t cal;
    } cal_st_t;

    cal_st_t st_d, st_q;
    logic [7:0] sec_nx, min_nx, h24_nx, h12_nx, day_nx, mon_nx, yr_nx, mon_end;
    logic       day_carry;

    always_comb begin
        st_d      = st_q;
        day_carry = 1'b0;
        sec_nx    = bcd_inc({1'b0, st_q.cal.sec});
        min_nx    = bcd_inc({1'b0, st_q.cal.min});
        h24_nx    = bcd_inc({2'b0, st_q.cal.hour});
        h12_nx    = bcd_inc({3'b0, st_q.cal.hour[4:0]});
        day_nx    = bcd_inc({2'b0, st_q.cal.day});
        mon_nx    = bcd_inc({3'b0, st_q.cal.mon});
        yr_nx     = bcd_inc(st_q.cal.year);
        mon_end   = last_day(st_q.cal.mon, st_q.cal.year);

        if (wr_time) begin
            case (wr_addr)
                A_SEC: begin
                    st_d.stale   = wr_data[7];
                    st_d.cal.sec = wr_data[6:0];
                end
                A_MIN:  st_d.cal.min  = wr_data[6:0];
                A_HOUR: st_d.cal.hour = wr_data[5:0];
                A_DAY:  st_d.cal.day  = wr_data[5:0];
                A_WDAY: st_d.cal.wday = wr_data[2:0];
                A_MON: begin
                    st_d.cal.cent = wr_data[7];
                    st_d.cal.mon  = wr_data[4:0];
                end
                A_YEAR: st_d.cal.year = wr_data;
                default: ;
            endcase
        end else if (sec_tick) begin
            if (st_q.cal.sec != 7'h59) begin
                st_d.cal.sec = sec_nx[6:0];
            end else begin
                st_d.cal.sec = 7'h00;
                if (st_q.cal.min != 7'h59) begin
                    st_d.cal.min = min_nx[6:0];
                end else begin
                    st_d.cal.min = 7'h00;
                    if (mode_12h) begin
                        if (st_q.cal.hour[4:0] == 5'h11) begin
                            st_d.cal.hour = {~st_q.cal.hour[5], 5'h12};
                            day_carry     = st_q.cal.hour[5];
                        end else if (st_q.cal.hour[4:0] == 5'h12) begin
                            st_d.cal.hour = {st_q.cal.hour[5], 5'h01};
                        end else begin
                            st_d.cal.hour = {st_q.cal.hour[5], h12_nx[4:0]};
                        end
                    end else if (st_q.cal.hour == 6'h23) begin
                        st_d.cal.hour = 6'h00;
                        day_carry     = 1'b1;
                    end else begin
                        st_d.cal.hour = h24_nx[5:0];
                    end

                    if (day_carry) begin
                        st_d.cal.wday = (st_q.cal.wday >= 3'd6) ? 3'd0 : st_q.cal.wday + 3'd1;
                        if (st_q.cal.day != mon_end[5:0]) begin
                            st_d.cal.day = day_nx[5:0];
                        end else begin
                            st_d.cal.day = 6'h01;
                            if (st_q.cal.mon != 5'h12) begin
                                st_d.cal.mon = mon_nx[4:0];
                            end else begin
                                st_d.cal.mon = 5'h01;
                                if (st_q.cal.year == 8'h99) begin
                                    st_d.cal.year = 8'h00;
                                    st_d.cal.cent = ~st_q.cal.cent;
                                end else begin
                                    st_d.cal.year = yr_nx;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stale    <= 1'b1;
            st_q.cal.sec  <= '0;
            st_q.cal.min  <= '0;
            st_q.cal.hour <= '0;
            st_q.cal.day  <= 6'h01;
            st_q.cal.wday <= '0;
            st_q.cal.mon  <= 5'h01;
            st_q.cal.year <= '0;
            st_q.cal.cent <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cal_q   = st_q.cal;
    assign stale_q = st_q.stale;
endmodule

// File: rtl/bcd_rtc_timer.sv
module bcd_rtc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q
);
    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.start = load_val;
            st_d.cnt   = load_val;
        end else if (tmr_tick && run) begin
            st_d.cnt = (st_q.cnt <= CNT_W'(1)) ? st_q.start : st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import bcd_rtc_pkg::*;
#(
    parameter int TICK_HZ = 32768,
    parameter int TMR_HZ  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data
);
    typedef struct packed {
        logic       stop;
        logic       h12;
        logic       t_en;
        logic [1:0] t_src;
        logic [7:0] rd;
    } ctl_st_t;

    ctl_st_t    ctl_d, ctl_q;
    cal_t       cal;
    logic       stale_flag;
    logic       sec_tick, tmr_tick;
    logic [7:0] tmr_cnt;
    logic       wr_time, wr_tcnt;
    logic       stop_flag;
    logic [6:0] sec_val;
    logic       cent_flag;

    assign wr_time   = wr_en && (addr >= A_SEC) && (addr <= A_YEAR);
    assign wr_tcnt   = wr_en && (addr == A_TCNT);
    assign stop_flag = ctl_q.stop;
    assign sec_val   = cal.sec;
    assign cent_flag = cal.cent;

    bcd_rtc_divider #(.TICK_HZ(TICK_HZ), .TMR_HZ(TMR_HZ)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .hold     (ctl_q.stop),
        .clr_low  (wr_time),
        .sec_tick (sec_tick),
        .tmr_tick (tmr_tick)
    );

    bcd_rtc_calendar cal_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .mode_12h (ctl_q.h12),
        .wr_time  (wr_time),
        .wr_addr  (addr),
        .wr_data  (wr_data),
        .cal_q    (cal),
        .stale_q  (stale_flag)
    );

    bcd_rtc_timer #(.CNT_W(8)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_tick (tmr_tick),
        .run      (ctl_q.t_en && (ctl_q.t_src == SRC_64HZ)),
        .load     (wr_tcnt),
        .load_val (wr_data),
        .cnt_q    (tmr_cnt)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && addr == A_CTRL1) begin
            ctl_d.stop = wr_data[BIT_STOP];
            ctl_d.h12  = wr_data[BIT_H12];
        end
        if (wr_en && addr == A_TCTL) begin
            ctl_d.t_en  = wr_data[BIT_TEN];
            ctl_d.t_src = wr_data[1:0];
        end
        if (rd_en) begin
            case (addr)
                A_CTRL1: ctl_d.rd = {2'b00, ctl_q.stop, 1'b0, ctl_q.h12, 3'b000};
                A_SEC:   ctl_d.rd = {stale_flag, cal.sec};
                A_MIN:   ctl_d.rd = {1'b0, cal.min};
                A_HOUR:  ctl_d.rd = {2'b00, cal.hour};
                A_DAY:   ctl_d.rd = {2'b00, cal.day};
                A_WDAY:  ctl_d.rd = {5'b00000, cal.wday};
                A_MON:   ctl_d.rd = {cal.cent, 2'b00, cal.mon};
                A_YEAR:  ctl_d.rd = cal.year;
                A_TCTL:  ctl_d.rd = {ctl_q.t_en, 5'b00000, ctl_q.t_src};
                A_TCNT:  ctl_d.rd = tmr_cnt;
                default: ctl_d.rd = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_data = ctl_q.rd;
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
    import bcd_rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic              stop_flag,
    input logic              sec_tick,
    input logic              tmr_tick,
    input logic              stale_flag,
    input logic [6:0]        sec_val,
    input logic              cent_flag,
    input logic [7:0]        tmr_cnt
);
    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag |-> (!sec_tick && !tmr_tick)); // R3

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && !(wr_en && addr == A_SEC)) |=> $stable(sec_val)); // R3

    AST_STALE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stale_flag && !(wr_en && addr == A_SEC)) |=> stale_flag); // R4

    AST_CENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !(wr_en && addr == A_MON)) |=> $stable(cent_flag)); // R8

    AST_REALIGN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= A_SEC && addr <= A_YEAR) |=> !sec_tick); // R9

    AST_TCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_tick && !(wr_en && addr == A_TCNT)) |=> $stable(tmr_cnt)); // R11

    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 4'h1 || addr == 4'hD)) |=> (rd_data == 8'h00)); // R2
endmodule

bind bcd_rtc_core bcd_rtc_core_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .stop_flag  (stop_flag),
    .sec_tick   (sec_tick),
    .tmr_tick   (tmr_tick),
    .stale_flag (stale_flag),
    .sec_val    (sec_val),
    .cent_flag  (cent_flag),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
    localparam int HALF_STROBES = 16384;
    localparam logic [3:0] R_CTL = 4'h0, R_SEC = 4'h2, R_MIN = 4'h3, R_HR = 4'h4,
                           R_DAY = 4'h5, R_WD = 4'h6, R_MON = 4'h7, R_YR = 4'h8,
                           R_TCTL = 4'hE, R_TCNT = 4'hF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_rtc_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        reg_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic strobe(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic void model_step(inout int s, inout int mi, inout int h, inout int d,
                                       inout int wd, inout int mo, inout int y, inout int c);
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0; wd = (wd + 1) % 7; d++;
                    if (d > dim(mo, y)) begin
                        d = 1; mo++;
                        if (mo == 13) begin
                            mo = 1; y++;
                            if (y == 100) begin y = 0; c = c ^ 1; end
                        end
                    end
                end
            end
        end
    endfunction

    task automatic load_time(input logic [7:0] ctl, input logic [7:0] s, input logic [7:0] mi,
                             input logic [7:0] h, input logic [7:0] d, input logic [7:0] wd,
                             input logic [7:0] mo, input logic [7:0] y);
        reg_wr(R_CTL, ctl | 8'h20);
        reg_wr(R_SEC, s); reg_wr(R_MIN, mi); reg_wr(R_HR, h); reg_wr(R_DAY, d);
        reg_wr(R_WD, wd); reg_wr(R_MON, mo); reg_wr(R_YR, y);
        reg_wr(R_CTL, ctl);
    endtask

    task automatic time_chk(input string req, input logic [7:0] s, input logic [7:0] mi,
                            input logic [7:0] h, input logic [7:0] d, input logic [7:0] wd,
                            input logic [7:0] mo, input logic [7:0] y);
        rd_chk({req, " sec"}, R_SEC, s);  rd_chk({req, " min"}, R_MIN, mi);
        rd_chk({req, " hour"}, R_HR, h);  rd_chk({req, " day"}, R_DAY, d);
        rd_chk({req, " wday"}, R_WD, wd); rd_chk({req, " month"}, R_MON, mo);
        rd_chk({req, " year"}, R_YR, y);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int s, mi, h, d, wd, mo, y, c;
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_chk("R1 sec", R_SEC, 8'h80);  rd_chk("R1 min", R_MIN, 8'h00);
        rd_chk("R1 hour", R_HR, 8'h00);  rd_chk("R1 day", R_DAY, 8'h01);
        rd_chk("R1 wday", R_WD, 8'h00);  rd_chk("R1 month", R_MON, 8'h01);
        rd_chk("R1 year", R_YR, 8'h00);  rd_chk("R1 ctl", R_CTL, 8'h00);
        rd_chk("R1 tctl", R_TCTL, 8'h00); rd_chk("R1 tcnt", R_TCNT, 8'h00);

        // R2 unused addresses and bits
        reg_wr(4'h1, 8'hFF); rd_chk("R2 addr1", 4'h1, 8'h00);
        reg_wr(4'hD, 8'hFF); rd_chk("R2 addrD", 4'hD, 8'h00);
        rd_chk("R2 addrA", 4'hA, 8'h00);
        reg_wr(R_CTL, 8'hFF); rd_chk("R2 ctl bits", R_CTL, 8'h28);
        reg_wr(R_CTL, 8'h20);

        // R4 stale flag survives other writes, follows seconds bit 7
        reg_wr(R_MIN, 8'h12);
        rd_chk("R4 stale kept", R_SEC, 8'h80);
        reg_wr(R_SEC, 8'h30);
        rd_chk("R4 stale cleared", R_SEC, 8'h30);

        // R10 timer control bits
        reg_wr(R_TCTL, 8'hFF); rd_chk("R10 tctl mask", R_TCTL, 8'h83);
        reg_wr(R_TCTL, 8'h81); rd_chk("R10 tctl 64Hz", R_TCTL, 8'h81);
        reg_wr(R_TCNT, 8'd64);

        // R3 release timing, R11 timer stepping
        reg_wr(R_CTL, 8'h00);
        strobe(512);
        rd_chk("R11 first tick", R_TCNT, 8'd63);
        strobe(HALF_STROBES - 512 - 1);
        rd_chk("R3 before half", R_SEC, 8'h30);
        rd_chk("R11 count 33", R_TCNT, 8'd33);
        strobe(1);
        rd_chk("R3 at half", R_SEC, 8'h31);
        rd_chk("R11 count 32", R_TCNT, 8'd32);
        strobe(HALF_STROBES);
        rd_chk("R11 reload mid-second", R_TCNT, 8'd64);
        rd_chk("R3 one step only", R_SEC, 8'h31);

        // R3 freeze while stopped
        reg_wr(R_CTL, 8'h20);
        strobe(1000);
        rd_chk("R3 frozen sec", R_SEC, 8'h31);
        rd_chk("R3 frozen tcnt", R_TCNT, 8'd64);

        // R10 non-64Hz source holds count
        reg_wr(R_TCTL, 8'h82);
        reg_wr(R_CTL, 8'h00);
        strobe(1024);
        rd_chk("R10 other source holds", R_TCNT, 8'd64);

        // R5 R7 R8 full rollover at end of year 99
        load_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
        strobe(HALF_STROBES);
        time_chk("R8 year rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h81, 8'h00);

        // R6 11 PM to 12 AM, with R7 end of non-leap February
        load_time(8'h08, 8'h59, 8'h59, 8'h31, 8'h28, 8'h03, 8'h02, 8'h23);
        strobe(HALF_STROBES);
        time_chk("R6 midnight", 8'h00, 8'h00, 8'h12, 8'h01, 8'h04, 8'h03, 8'h23);

        // R6 11 AM to 12 PM, R9 realign by a time write mid-run
        load_time(8'h08, 8'h59, 8'h59, 8'h11, 8'h10, 8'h02, 8'h05, 8'h23);
        strobe(100);
        reg_wr(R_MIN, 8'h59);
        strobe(HALF_STROBES - 1);
        rd_chk("R9 no early step", R_SEC, 8'h59);
        strobe(1);
        time_chk("R6 noon", 8'h00, 8'h00, 8'h32, 8'h10, 8'h02, 8'h05, 8'h23);

        // R7 leap February
        load_time(8'h00, 8'h59, 8'h59, 8'h23, 8'h28, 8'h05, 8'h02, 8'h24);
        strobe(HALF_STROBES);
        time_chk("R7 leap day", 8'h00, 8'h00, 8'h00, 8'h29, 8'h06, 8'h02, 8'h24);

        // R5 R7 R8 random dates biased to field limits
        for (int it = 0; it < 3; it++) begin
            c  = int'($urandom_range(1, 0));
            y  = ($urandom_range(3, 0) == 0) ? 99 : int'($urandom_range(99, 0));
            mo = ($urandom_range(1, 0) == 1) ? 12 : int'($urandom_range(12, 1));
            d  = ($urandom_range(1, 0) == 1) ? dim(mo, y) : int'($urandom_range(dim(mo, y), 1));
            h  = ($urandom_range(1, 0) == 1) ? 23 : int'($urandom_range(23, 0));
            mi = ($urandom_range(3, 0) != 0) ? 59 : int'($urandom_range(59, 0));
            s  = ($urandom_range(3, 0) != 0) ? 59 : int'($urandom_range(59, 0));
            wd = int'($urandom_range(6, 0));
            load_time(8'h00, to_bcd(s), to_bcd(mi), to_bcd(h), to_bcd(d), to_bcd(wd),
                      to_bcd(mo) | (c != 0 ? 8'h80 : 8'h00), to_bcd(y));
            strobe(HALF_STROBES);
            model_step(s, mi, h, d, wd, mo, y, c);
            time_chk("R5 R7 random", to_bcd(s), to_bcd(mi), to_bcd(h), to_bcd(d), to_bcd(wd),
                     to_bcd(mo) | (c != 0 ? 8'h80 : 8'h00), to_bcd(y));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule